// File: doc/BRIEF.md
# DMA Channel Address and Count Unit

This block keeps the per-channel transfer state of a four-channel DMA engine. Every channel owns a 16-bit memory address and a 14-bit cycle counter with a 2-bit transfer-type code. The CPU loads these values over an 8-bit register port while the engine is not bus master. Each register is written and read as two bytes, low byte first. A shared byte-pointer flip-flop steers each access to the correct byte.

While the engine owns the bus, an external sequencer presents one granted DMA cycle at a time, together with the active channel number. The unit drives that channel's current address and transfer type. At the clock edge it advances the address by one and decrements the counter. A count of N cycles is programmed as N-1. The terminal-count output goes high in the cycle that consumes the last count. A status register gathers sticky per-channel terminal-count flags and an update flag.

With auto-load set, a terminal count on channel 2 starts a one-cycle update. That update copies channel 3's address, count and type into channel 2, so that blocks can repeat or chain.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every address, count and type field is zero, no channel is enabled, auto-load is off, the status register reads 0x00 and tc_o is low.
- R2: Register index 2*c selects channel c's address and 2*c+1 selects its count word. One byte pointer, shared by all channels, picks the low byte on the first access and the high byte on the next. Every read or write of a channel register toggles the pointer. A write to the mode register at index 8 resets the pointer to the low byte.
- R3: In the count word, the high byte's bits 7:6 hold the transfer type and bits 5:0 hold count bits 13:8. The active channel's type appears on xfer_op_o.
- R4: During a DMA cycle on an enabled channel, mem_addr_o shows that channel's address before the step. At the clock edge the address increments by one and the count decrements by one.
- R5: tc_o is high exactly in a DMA cycle on an enabled channel whose count is zero. A stored count of N-1 therefore gives tc_o on the Nth cycle.
- R6: Mode-register bits 3:0 enable channels 0 to 3 and appear on chan_en_o. A DMA cycle on a disabled channel changes no state and keeps tc_o low.
- R7: A status read (index 8) returns the terminal-count flags of channels 0 to 3 in bits 3:0 and the update flag in bit 4. A terminal count sets the channel's flag at the clock edge. A status read clears all the flags, except that a flag set in the same cycle as the read survives.
- R8: With mode bit 7 set, a terminal count on channel 2 raises the update flag for the next cycle only. At the end of that cycle, channel 2 is loaded with channel 3's address, count and type. A status read does not clear the update flag.
- R9: While master_i is high, CPU reads and writes have no effect on any register or on the byte pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | Engine owns the bus; CPU access blocked |
| cs_i | input | 1 | CPU register select |
| wr_i | input | 1 | CPU write strobe |
| rd_i | input | 1 | CPU read strobe |
| reg_addr_i | input | 4 | Register index |
| wdata_i | input | 8 | CPU write data |
| rdata_o | output | 8 | Byte of the addressed register |
| dma_cycle_i | input | 1 | Granted DMA cycle |
| dma_ch_i | input | 2 | Channel served by this cycle |
| mem_addr_o | output | 16 | Current address of the active channel |
| xfer_op_o | output | 2 | Transfer type of the active channel |
| tc_o | output | 1 | Terminal count, active high |
| chan_en_o | output | 4 | Channel enables |

## Verification
The checker runs on every cycle and checks the following:
- tc_o only ever appears inside a DMA cycle on an enabled channel.
- Each terminal count leaves its status flag set.
- The update flag never lasts more than one cycle.
- Every step without a reload moves a channel's address by exactly one.
- The enables stay frozen while master_i is high.

The byte ordering and the byte-pointer reset, the position of the type bits, and the N-1 count semantics can only be shown by the bench's scenarios. The same holds for clear-on-read of the status register, and for the actual values copied from channel 3 into channel 2.

// File: rtl/dma_pkg.sv
package dma_pkg;
  parameter int ADDR_W = 16;
  parameter int CNT_W  = 14;
  parameter int OP_W   = 2;
  parameter int BYTE_W = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [OP_W-1:0]   op;
    logic [CNT_W-1:0]  cnt;
  } chan_t;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic toggle_i,
  input  logic clear_i,
  output logic hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_o <= 1'b0;
    else if (clear_i)  hi_o <= 1'b0;
    else if (toggle_i) hi_o <= ~hi_o;
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              sel_cnt_i,
  input  logic              hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              step_i,
  input  logic              reload_i,
  input  chan_t             ld_i,
  output chan_t             st_o
);
  // reload beats step beats cpu write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o <= '0;
    end else if (reload_i) begin
      st_o <= ld_i;
    end else if (step_i) begin
      st_o.addr <= st_o.addr + 1'b1;
      st_o.cnt  <= st_o.cnt - 1'b1;
    end else if (wr_i) begin
      if (!sel_cnt_i) begin
        if (hi_i) st_o.addr[ADDR_W-1:BYTE_W] <= wdata_i;
        else      st_o.addr[BYTE_W-1:0]      <= wdata_i;
      end else begin
        if (hi_i) {st_o.op, st_o.cnt[CNT_W-1:BYTE_W]} <= wdata_i;
        else      st_o.cnt[BYTE_W-1:0]                <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/dma_status.sv
module dma_status #(
  parameter int NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] tc_set_i,
  input  logic           clr_i,
  input  logic           auto_tc_i,
  output logic [NCH-1:0] tc_flags_o,
  output logic           upd_o
);
  // set wins over read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_flags_o <= '0;
      upd_o      <= 1'b0;
    end else begin
      tc_flags_o <= (clr_i ? '0 : tc_flags_o) | tc_set_i;
      upd_o      <= auto_tc_i;
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int AUTO_DST = 2,
  parameter int AUTO_SRC = 3,
  parameter int AUTO_BIT = 7,
  localparam int CHW     = $clog2(NCH),
  localparam int RAW     = CHW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [RAW-1:0]    reg_addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              dma_cycle_i,
  input  logic [CHW-1:0]    dma_ch_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [OP_W-1:0]   xfer_op_o,
  output logic              tc_o,
  output logic [NCH-1:0]    chan_en_o
);
  localparam logic [RAW-1:0] MODE_IDX = RAW'(2 * NCH);

  logic cpu_ok, cpu_wr, cpu_rd, is_chan, is_mode, ptr_hi;
  logic [CHW-1:0] ch_sel;
  logic [NCH-1:0] en_q, step_vec, tc_vec, reload_vec, tc_flags;
  logic [NCH*ADDR_W-1:0] addr_flat;
  logic auto_q, upd_q;
  chan_t chan_q [NCH];
  chan_t act, sel;

  assign cpu_ok  = cs_i & ~master_i;
  assign cpu_wr  = cpu_ok & wr_i;
  assign cpu_rd  = cpu_ok & rd_i & ~wr_i;
  assign is_mode = (reg_addr_i == MODE_IDX);
  assign is_chan = (reg_addr_i < MODE_IDX);
  assign ch_sel  = reg_addr_i[CHW:1];

  dma_byte_ptr u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .toggle_i ((cpu_wr | cpu_rd) & is_chan),
    .clear_i  (cpu_wr & is_mode),
    .hi_o     (ptr_hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      auto_q <= 1'b0;
    end else if (cpu_wr && is_mode) begin
      en_q   <= wdata_i[NCH-1:0];
      auto_q <= wdata_i[AUTO_BIT];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign step_vec[i]   = dma_cycle_i & (dma_ch_i == CHW'(i)) & en_q[i];
    assign tc_vec[i]     = step_vec[i] & (chan_q[i].cnt == '0);
    assign reload_vec[i] = (i == AUTO_DST) & upd_q;
    assign addr_flat[i*ADDR_W +: ADDR_W] = chan_q[i].addr;

    dma_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (cpu_wr & is_chan & (ch_sel == CHW'(i))),
      .sel_cnt_i (reg_addr_i[0]),
      .hi_i      (ptr_hi),
      .wdata_i   (wdata_i),
      .step_i    (step_vec[i]),
      .reload_i  (reload_vec[i]),
      .ld_i      (chan_q[AUTO_SRC]),
      .st_o      (chan_q[i])
    );
  end

  dma_status #(.NCH(NCH)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tc_set_i   (tc_vec),
    .clr_i      (cpu_rd & is_mode),
    .auto_tc_i  (auto_q & tc_vec[AUTO_DST]),
    .tc_flags_o (tc_flags),
    .upd_o      (upd_q)
  );

  assign act        = chan_q[dma_ch_i];
  assign sel        = chan_q[ch_sel];
  assign mem_addr_o = act.addr;
  assign xfer_op_o  = act.op;
  assign tc_o       = |tc_vec;
  assign chan_en_o  = en_q;

  always_comb begin
    rdata_o = '0;
    if (is_chan) begin
      if (!reg_addr_i[0]) rdata_o = ptr_hi ? sel.addr[ADDR_W-1:BYTE_W] : sel.addr[BYTE_W-1:0];
      else                rdata_o = ptr_hi ? {sel.op, sel.cnt[CNT_W-1:BYTE_W]} : sel.cnt[BYTE_W-1:0];
    end else if (is_mode) begin
      rdata_o = BYTE_W'({upd_q, tc_flags});
    end
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 16,
  parameter int CHW    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              master_i,
  input logic              dma_cycle_i,
  input logic [CHW-1:0]    dma_ch_i,
  input logic              tc_o,
  input logic [NCH-1:0]    chan_en_o,
  input logic              upd_q,
  input logic [NCH-1:0]    tc_flags,
  input logic [NCH-1:0]    step_vec,
  input logic [NCH-1:0]    reload_vec,
  input logic [NCH*ADDR_W-1:0] addr_flat
);
  // R5
  tc_in_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> dma_cycle_i);

  // R6
  tc_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> chan_en_o[dma_ch_i]);

  // R7
  tc_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> tc_flags[$past(dma_ch_i)]);

  // R8
  upd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> !upd_q);

  // R9
  master_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i |=> $stable(chan_en_o));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R4
    addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_vec[i] && !reload_vec[i]) |=>
        addr_flat[i*ADDR_W +: ADDR_W] == $past(addr_flat[i*ADDR_W +: ADDR_W]) + 1'b1);
  end
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NCH(NCH), .ADDR_W(dma_pkg::ADDR_W), .CHW(CHW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .master_i    (master_i),
  .dma_cycle_i (dma_cycle_i),
  .dma_ch_i    (dma_ch_i),
  .tc_o        (tc_o),
  .chan_en_o   (chan_en_o),
  .upd_q       (upd_q),
  .tc_flags    (tc_flags),
  .step_vec    (step_vec),
  .reload_vec  (reload_vec),
  .addr_flat   (addr_flat)
);

// File: tb/dma_chan_regs_test.sv
`timescale 1ns/1ps
module dma_chan_regs_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic master = 0, cs = 0, wr = 0, rd = 0, dma_cycle = 0;
  logic [3:0] reg_addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [1:0] dma_ch = '0, xfer_op;
  logic [15:0] mem_addr;
  logic tc;
  logic [3:0] chan_en;
  int checks = 0, fails = 0;

  typedef struct {
    string req;
    logic [15:0] addr;
    logic [1:0] op;
    logic tc;
  } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;

  dma_chan_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .cs_i(cs), .wr_i(wr), .rd_i(rd),
    .reg_addr_i(reg_addr), .wdata_i(wdata), .rdata_o(rdata), .dma_cycle_i(dma_cycle),
    .dma_ch_i(dma_ch), .mem_addr_o(mem_addr), .xfer_op_o(xfer_op), .tc_o(tc),
    .chan_en_o(chan_en)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic release_bus();
    @(posedge clk); #1;
    cs = 0; wr = 0; rd = 0; dma_cycle = 0;
  endtask

  task automatic cpu_write(logic [3:0] a, logic [7:0] d);
    cs = 1; wr = 1; reg_addr = a; wdata = d;
    @(negedge clk);
    release_bus();
  endtask

  task automatic cpu_read(logic [3:0] a, string req, logic [7:0] exp);
    cs = 1; rd = 1; reg_addr = a;
    @(negedge clk);
    check(req, rdata, exp);
    release_bus();
  endtask

  task automatic dma(logic [1:0] ch, string req, logic [15:0] a, logic [1:0] op, logic t);
    item_t it;
    it.req = req; it.addr = a; it.op = op; it.tc = t;
    exp_q.push_back(it);
    dma_cycle = 1; dma_ch = ch;
    @(negedge clk);
    release_bus();
  endtask

  // monitor: pops expected results as DMA cycles occur
  always @(negedge clk) begin
    if (rst_n && dma_cycle) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL monitor unexpected cycle actual=1 expected=0");
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check({e.req, " addr"}, mem_addr, e.addr);
        check({e.req, " op"}, xfer_op, e.op);
        check({e.req, " tc"}, tc, e.tc);
      end
    end
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #45 rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    check("R1 en", chan_en, 4'h0);
    check("R1 tc", tc, 1'b0);
    cpu_read(4'd8, "R1 status", 8'h00);
    cpu_read(4'd0, "R1 addr lo", 8'h00);
    cpu_read(4'd0, "R1 addr hi", 8'h00);

    // program ch0: addr 0x1234, 3 cycles (stored 2), type 1
    cpu_write(4'd0, 8'h34); cpu_write(4'd0, 8'h12);
    cpu_write(4'd1, 8'h02); cpu_write(4'd1, 8'h40);
    cpu_read(4'd0, "R2 addr lo", 8'h34);
    cpu_read(4'd0, "R2 addr hi", 8'h12);
    cpu_read(4'd1, "R2 cnt lo", 8'h02);
    cpu_read(4'd1, "R3 cnt hi", 8'h40);

    cpu_write(4'd8, 8'h01);
    check("R6 enable", chan_en, 4'h1);
    dma(2'd0, "R4 c0 first", 16'h1234, 2'd1, 1'b0);
    dma(2'd0, "R4 c0 second", 16'h1235, 2'd1, 1'b0);
    dma(2'd0, "R5 c0 last", 16'h1236, 2'd1, 1'b1);
    cpu_read(4'd8, "R7 status tc0", 8'h01);
    cpu_read(4'd8, "R7 cleared", 8'h00);

    // R6 disabled channel
    dma(2'd1, "R6 c1 disabled", 16'h0000, 2'd0, 1'b0);
    cpu_read(4'd2, "R6 c1 addr lo", 8'h00);
    cpu_read(4'd2, "R6 c1 addr hi", 8'h00);
    cpu_read(4'd8, "R6 no flag", 8'h00);

    // R9 master blocks CPU
    master = 1;
    cpu_write(4'd8, 8'h0F);
    cpu_write(4'd0, 8'hEE);
    master = 0;
    check("R9 enables kept", chan_en, 4'h1);
    cpu_read(4'd0, "R9 addr lo kept", 8'h37);
    cpu_read(4'd0, "R9 addr hi kept", 8'h12);

    // R8 auto-load: ch2 2 cycles type 2, ch3 source type 3
    cpu_write(4'd4, 8'h00); cpu_write(4'd4, 8'h01);
    cpu_write(4'd5, 8'h01); cpu_write(4'd5, 8'h80);
    cpu_write(4'd6, 8'h00); cpu_write(4'd6, 8'h20);
    cpu_write(4'd7, 8'h04); cpu_write(4'd7, 8'hC0);
    cpu_write(4'd8, 8'h85);
    dma(2'd2, "R8 c2 first", 16'h0100, 2'd2, 1'b0);
    dma(2'd2, "R8 c2 tc", 16'h0101, 2'd2, 1'b1);
    cpu_read(4'd8, "R8 update flag", 8'h14);
    cpu_read(4'd8, "R8 flag ended", 8'h00);
    dma(2'd2, "R8 reloaded", 16'h2000, 2'd3, 1'b0);
    cpu_read(4'd5, "R4 count stepped", 8'h03);
    cpu_read(4'd5, "R8 type copied", 8'hC0);

    // R2 pointer reset by mode write
    cpu_write(4'd2, 8'h11);
    cpu_write(4'd8, 8'h85);
    cpu_write(4'd2, 8'hAA); cpu_write(4'd2, 8'hBB);
    cpu_read(4'd2, "R2 ptr lo", 8'hAA);
    cpu_read(4'd2, "R2 ptr hi", 8'hBB);

    repeat (2) @(posedge clk);
    check("R4 queue drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule